// File: doc/BRIEF.md
# GPIO Pin-Change Interrupt Controller

This block watches up to 32 parallel I/O lines and reports any change of level on them, whether the line rises or falls. Every line passes through a synchroniser. Each change is caught in a per-line change flag. The flags are ANDed with a per-line enable mask, and the results are combined into one interrupt output. Capture does not depend on what the line is used for. A line that drives a peripheral, or that is an output, still reports its changes. The mask decides only whether a change raises the interrupt.

Software reaches the block over a small word-addressed register bus. There are four registers:

| Word address | Name | Access | Use |
|---|---|---|---|
| 0 | enable | write only | sets mask bits |
| 1 | disable | write only | clears mask bits |
| 2 | mask | read only | returns the mask |
| 3 | change status | read only | returns the flags, then clears them |

Reading the change status returns the flags and clears them in the same access, so one read both reports the events and acknowledges them. The parameter `LINE_MASK` sets which line positions exist. Any position left out of it is inert.

The bus has no data stream and no handshake. A write is accepted in any cycle where `bus_en_i` and `bus_we_i` are both high. A read is a cycle where `bus_en_i` is high and `bus_we_i` is low. Read data is combinational and valid during that cycle.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, the mask and the change status read as zero and `irq_o` is low. Lines that are held steady through reset and afterwards report no change.
- R2: A rising or a falling level on an existing line sets the matching status bit. The bit can be read no later than the third rising clock edge after the line changes. Several lines changing together set all of their bits. A one-cycle pulse on a line sets its bit.
- R3: A write of value V to word address 0 (enable) sets each mask bit n for which V bit n is 1. Mask bits where V holds 0 keep their value.
- R4: A write of value V to word address 1 (disable) clears each mask bit n for which V bit n is 1. Mask bits where V holds 0 keep their value.
- R5: A read of word address 2 returns the mask, with bit n belonging to line n. Reads of word addresses 0 and 1 return zero.
- R6: A status bit is set by a change on its line even when the line's mask bit is 0.
- R7: `irq_o` is high exactly when some bit is set both in the status register and in the mask.
- R8: A read of word address 3 returns the status, with bit n belonging to line n, and clears every status bit at the end of that cycle.
- R9: A change that is detected in the same cycle as a status read is not lost. Its bit is set after the clear.
- R10: For a line position whose `LINE_MASK` bit is 0: writes to that position have no effect, the position reads as zero in the mask and in the status, and activity on that input never sets status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pins_i | input | 32 | Asynchronous I/O line levels |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the read cycle |
| irq_o | output | 1 | Combined pin-change interrupt |

## Verification
The bench tests the following corner cases:

- **Change during a status read.** A change is timed so that it is detected in the cycle of a status read. A design that applies the clear after the set would drop this event, and the follow-up read would return zero.
- **Lines that do not exist.** The bench writes all ones to enable and toggles an absent line. A design that does not gate those positions would show stray mask or status bits.
- **Writes of zero.** Zero data is written to both enable and disable. This catches a design that overwrites the mask instead of only setting or clearing bits.
- **Steady inputs through reset.** Lines sit at a pattern that is not zero while reset is held. A design that leaves its previous-value register at zero would report false changes as soon as reset is released.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE  = 2'd0,
    RA_DISABLE = 2'd1,
    RA_MASK    = 2'd2,
    RA_STATUS  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int unsigned          WIDTH     = 32,
  parameter int unsigned          STAGES    = 2,
  parameter logic [WIDTH-1:0]     LINE_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    if (LINE_MASK[b]) begin : g_live
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= {STAGES{raw_i[b]}};
        else         chain_q <= {chain_q[STAGES-2:0], raw_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
    end else begin : g_absent
      assign sync_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned      WIDTH     = 32,
  parameter logic [WIDTH-1:0] LINE_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] prev_q;

  // During reset the previous value follows the live pins, as the
  // synchroniser stages do, so that release reports no phantom edge.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= raw_i & LINE_MASK;
    else         prev_q <= sync_i;
  end

  assign chg_o = (sync_i ^ prev_q) & LINE_MASK;
endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter logic [REG_W-1:0] LINE_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  chg_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [REG_W-1:0]  mask_o,
  output logic [REG_W-1:0]  status_o,
  output logic              irq_o
);
  logic [REG_W-1:0] mask_q, status_q;
  logic             wr_en, wr_dis, rd_stat;
  reg_addr_e        addr;

  assign addr    = reg_addr_e'(bus_addr_i);
  assign wr_en   = bus_en_i &  bus_we_i & (addr == RA_ENABLE);
  assign wr_dis  = bus_en_i &  bus_we_i & (addr == RA_DISABLE);
  assign rd_stat = bus_en_i & ~bus_we_i & (addr == RA_STATUS);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_q | (bus_wdata_i & LINE_MASK);
    end else if (wr_dis) begin
      mask_q <= mask_q & ~bus_wdata_i;
    end
  end

  // Clear first, then merge fresh changes: an event seen in the read
  // cycle survives into the next status value.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= ((rd_stat ? '0 : status_q) | chg_i) & LINE_MASK;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i) begin
      unique case (addr)
        RA_MASK:   bus_rdata_o = mask_q;
        RA_STATUS: bus_rdata_o = status_q;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o    = |(status_q & mask_q);
  assign mask_o   = mask_q;
  assign status_o = status_q;
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gpio_chg_pkg::*;
#(
  parameter logic [REG_W-1:0] LINE_MASK   = 32'h0FFF_FFFF,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  pins_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0] sync_w, chg_w, mask_w, status_w;

  gpio_chg_sync #(
    .WIDTH(REG_W), .STAGES(SYNC_STAGES), .LINE_MASK(LINE_MASK)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(pins_i), .sync_o(sync_w)
  );

  gpio_chg_detect #(
    .WIDTH(REG_W), .LINE_MASK(LINE_MASK)
  ) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(pins_i),
    .sync_i(sync_w), .chg_o(chg_w)
  );

  gpio_chg_regs #(
    .LINE_MASK(LINE_MASK)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .chg_i(chg_w),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .mask_o(mask_w), .status_o(status_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk #(
  parameter logic [31:0] LINE_MASK = '1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_en_i,
  input logic        bus_we_i,
  input logic [1:0]  bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic        irq_o,
  input logic [31:0] mask_w,
  input logic [31:0] status_w,
  input logic [31:0] chg_w
);
  logic wr_e, wr_d, rd_s;
  assign wr_e = bus_en_i &  bus_we_i & (bus_addr_i == 2'd0);
  assign wr_d = bus_en_i &  bus_we_i & (bus_addr_i == 2'd1);
  assign rd_s = bus_en_i & ~bus_we_i & (bus_addr_i == 2'd3);

  // R3
  enable_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_e |=> ((mask_w & $past(bus_wdata_i) & LINE_MASK) == ($past(bus_wdata_i) & LINE_MASK)));

  // R4
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d |=> ((mask_w & $past(bus_wdata_i)) == 32'd0));

  // R6
  change_captured_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_w != 32'd0) |=> ((status_w & $past(chg_w)) == $past(chg_w)));

  // R9
  read_clear_keeps_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_s |=> ((status_w & ~$past(chg_w)) == 32'd0));

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_s && !wr_d) |=> irq_o);

  // R10
  absent_lines_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_w | status_w) & ~LINE_MASK) == 32'd0);
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.LINE_MASK(LINE_MASK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .irq_o(irq_o),
  .mask_w(mask_w), .status_w(status_w), .chg_w(chg_w)
);

// File: tb/gpio_chg_irq_bench.sv
module gpio_chg_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = 32'hA5A5_0F0F;
  logic        en = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  gpio_chg_irq u_gpio_chg_irq (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    tick(); en = 1; we = 1; addr = a; wdata = d;
    tick(); en = 0; we = 0;
  endtask

  // Driver: pushes the expected read value, then issues the read.
  task automatic bus_read(logic [1:0] a, logic [31:0] exp, string tag);
    exp_t item;
    item.exp = exp; item.tag = tag;
    tick(); sb_q.push_back(item); en = 1; we = 0; addr = a;
    tick(); en = 0;
  endtask

  task automatic flip(logic [31:0] m);
    tick(); pins = pins ^ m;
    repeat (3) tick();
  endtask

  // Monitor: compares read data with the scoreboard away from the edge.
  always @(negedge clk) begin
    if (en && !we) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expectation actual=%h expected=none", rdata);
      end else begin
        exp_t item;
        item = sb_q.pop_front();
        check(item.tag, rdata, item.exp);
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state, steady pins report nothing
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(2'd2, 32'd0, "R1 mask after reset");
    bus_read(2'd3, 32'd0, "R1 status after reset");
    // R2 falling change, R6 captured while masked
    flip(32'h0000_0008);
    check("R6 irq masked", {31'd0, irq}, 32'd0);
    bus_read(2'd3, 32'h0000_0008, "R2/R6 status after fall");
    bus_read(2'd3, 32'd0, "R8 status cleared by read");
    // R3 / R4 / R5 mask handling
    bus_write(2'd0, 32'h0000_0110);
    bus_read(2'd2, 32'h0000_0110, "R3 enable sets");
    bus_write(2'd0, 32'd0);
    bus_read(2'd2, 32'h0000_0110, "R3 enable zero no effect");
    bus_write(2'd1, 32'h0000_0100);
    bus_read(2'd2, 32'h0000_0010, "R4 disable clears");
    bus_write(2'd1, 32'd0);
    bus_read(2'd2, 32'h0000_0010, "R4 disable zero no effect");
    bus_read(2'd0, 32'd0, "R5 enable address reads zero");
    bus_read(2'd1, 32'd0, "R5 disable address reads zero");
    // R7 interrupt follows status AND mask
    flip(32'h0000_0020);
    check("R7 irq unmasked line", {31'd0, irq}, 32'd0);
    flip(32'h0000_0010);
    check("R7 irq masked line", {31'd0, irq}, 32'd1);
    bus_read(2'd3, 32'h0000_0030, "R8 status two lines");
    check("R7 irq after status read", {31'd0, irq}, 32'd0);
    // R10 absent lines
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd2, 32'h0FFF_FFFF, "R10 mask absent bits");
    flip(32'h4000_0000);
    check("R10 irq absent line", {31'd0, irq}, 32'd0);
    bus_read(2'd3, 32'd0, "R10 status absent line");
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd2, 32'd0, "R4 disable all");
    // R9 change coinciding with status read
    flip(32'h0000_0004);
    tick(); pins = pins ^ 32'h0000_0080;
    tick();
    bus_read(2'd3, 32'h0000_0004, "R9 read during change");
    bus_read(2'd3, 32'h0000_0080, "R9 change kept after clear");
    // R2 mixed rising and falling lines together
    flip(32'h00F0_000F);
    bus_read(2'd3, 32'h00F0_000F, "R2 mixed directions");
    // R2 one-cycle pulse
    tick(); pins[9] = ~pins[9];
    tick(); pins[9] = ~pins[9];
    repeat (4) tick();
    bus_read(2'd3, 32'h0000_0200, "R2 short pulse");
    repeat (2) tick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule